// File: doc/BRIEF.md
# Multi-mode operand address generator

This block works out where a load operand lives in memory. A start pulse brings in a 3-bit mode code, a 16-bit immediate, two register selectors and an access-size code. The block reads the selected general-purpose registers through two combinational read ports and forms a 32-bit effective address in one of six ways: a fixed address from the immediate, a register used as a pointer, a pointer plus a signed displacement, a pointer plus an index register, a pointer to a pointer, and a pointer that is stepped forward or backward after use.

For the pointer-to-pointer mode the block issues one read on a request/acknowledge memory port and takes the returned word as the address. It stays busy and ignores new start pulses until that address has been delivered. For the stepping modes it returns the updated pointer on a register write port in the same cycle that the address is presented. The block does not perform the load, decode instructions or translate addresses.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, with no start pulse yet, `addr_valid`, `illegal`, `wb_en`, `mem_req` and `busy` are all 0.
- R2: Mode code 0 (fixed address): `addr_out` equals the 16-bit immediate zero-extended to 32 bits, with `addr_valid` high in the cycle after the clock edge that samples `start`.
- R3: Mode code 1 (pointer): `addr_out` equals the register selected by `base_sel`, valid one cycle after start.
- R4: Mode code 2 (pointer plus displacement): `addr_out` equals the base register plus the immediate sign-extended from bit 15, modulo 2^32.
- R5: Mode code 3 (pointer plus index): `addr_out` equals the base register plus the register selected by `index_sel`, modulo 2^32.
- R6: Mode code 4 (pointer to pointer): one cycle after start, `mem_req` rises with `mem_addr` equal to the base register; `mem_req` and `mem_addr` hold until `mem_ack` is sampled high; in the next cycle `addr_valid` is high and `addr_out` equals the `mem_rdata` sampled with that acknowledge.
- R7: Mode code 5 (step up): `addr_out` equals the base register; in the same cycle `wb_en` is high, `wb_sel` equals `base_sel` and `wb_data` is the base plus the step.
- R8: Mode code 6 (step down): as R7 but `wb_data` is the base minus the step.
- R9: The step is taken from `size`: code 0 gives 1, code 1 gives 2, codes 2 and 3 give 4.
- R10: Mode code 7 raises `illegal` for one cycle, one cycle after start, with `addr_valid` and `wb_en` low.
- R11: While `busy` is high (from the cycle after a mode-4 start through the cycle its address is valid) a start pulse is ignored and produces no address, flag or writeback.
- R12: `addr_valid` is a one-cycle pulse per accepted operation; `wb_en` is high only together with `addr_valid`; modes other than 5 and 6 never raise `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to compute an address |
| mode | input | 3 | Addressing mode code (0..7) |
| imm | input | 16 | Immediate: fixed address or signed displacement |
| base_sel | input | 4 | Base register number |
| index_sel | input | 4 | Index register number |
| size | input | 2 | Access-size code for the step |
| rd_a_addr | output | 4 | Register read port A selector (base) |
| rd_a_data | input | 32 | Register read port A data |
| rd_b_addr | output | 4 | Register read port B selector (index) |
| rd_b_data | input | 32 | Register read port B data |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory acknowledge, data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| wb_en | output | 1 | Base register write enable |
| wb_sel | output | 4 | Base register number to write |
| wb_data | output | 32 | Updated base value |
| addr_valid | output | 1 | Effective address valid strobe |
| addr_out | output | 32 | Effective address |
| illegal | output | 1 | Unsupported mode code strobe |
| busy | output | 1 | Pointer-to-pointer operation in progress |

## Verification
The hardest condition to reach is a start pulse arriving while a pointer-to-pointer read is outstanding, since it only exists when the memory side delays its acknowledge. The bench's memory model withholds `mem_ack` for several cycles, injects a fixed-address start during that window, and then confirms that the address finally delivered is the fetched word and that no second strobe follows. The stepping modes are checked end to end: the bench register file takes the writeback, and a later pointer-mode operation reads the stepped value back through the ports.

// File: rtl/opaddr_pkg.sv
// Shared types for the operand address generator.
// Assumes mode codes are fixed by the instruction encoding.
package opaddr_pkg;

    typedef enum logic [2:0] {
        AM_ABS  = 3'd0,
        AM_RIND = 3'd1,
        AM_DISP = 3'd2,
        AM_IDX  = 3'd3,
        AM_MIND = 3'd4,
        AM_AINC = 3'd5,
        AM_ADEC = 3'd6,
        AM_BAD  = 3'd7
    } amode_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_DONE = 2'd2
    } fstate_t;

endpackage

// File: rtl/opaddr_calc.sv
// Combinational address arithmetic for every mode that needs no memory read.
// Assumes register values are already presented by the read ports.
module opaddr_calc
    import opaddr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IMMW = 16
) (
    input  amode_t          mode,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   index,
    input  logic [1:0]      size,
    output logic [AW-1:0]   ea,
    output logic [AW-1:0]   wb_val,
    output logic            is_auto,
    output logic            is_bad
);
    localparam int EXTW = AW - IMMW;

    logic [AW-1:0] imm_zx;
    logic [AW-1:0] imm_sx;
    logic [AW-1:0] step;

    // Extend the immediate both ways.
    always_comb begin
        imm_zx = {{EXTW{1'b0}}, imm};
        imm_sx = {{EXTW{imm[IMMW-1]}}, imm};
    end

    // Translate the size code into a byte step.
    always_comb begin
        case (size)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            default: step = AW'(4);
        endcase
    end

    // Pick the effective address for the requested mode.
    always_comb begin
        case (mode)
            AM_ABS:  ea = imm_zx;
            AM_DISP: ea = base + imm_sx;
            AM_IDX:  ea = base + index;
            default: ea = base;
        endcase
    end

    // Form the stepped base value and mode class flags.
    always_comb begin
        wb_val  = (mode == AM_ADEC) ? base - step : base + step;
        is_auto = (mode == AM_AINC) || (mode == AM_ADEC);
        is_bad  = (mode == AM_BAD);
    end

endmodule

// File: rtl/opaddr_fetch.sv
// Sequencer for the pointer-to-pointer mode: one memory read, then done.
// Assumes the memory returns data in the same cycle as its acknowledge.
module opaddr_fetch
    import opaddr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] ptr,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          hit,
    output logic          busy
);
    fstate_t       state;
    logic [AW-1:0] ptr_q;

    // Advance the sequencer and hold the pointer for the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            ptr_q <= '0;
        end else begin
            case (state)
                FS_IDLE: if (launch) begin
                    state <= FS_WAIT;
                    ptr_q <= ptr;
                end
                FS_WAIT: if (mem_ack) state <= FS_DONE;
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Drive the request and report completion.
    always_comb begin
        mem_req  = (state == FS_WAIT);
        mem_addr = ptr_q;
        hit      = (state == FS_WAIT) && mem_ack;
        busy     = (state != FS_IDLE);
    end

    // R6
    // req_hold_chk: an unanswered request stays up with the same address
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R11
    // no_relaunch_chk: the sequencer is never restarted while occupied
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req) |=> !mem_req);

endmodule

// File: rtl/opaddr_gen.sv
// Top of the operand address generator. Accepts a start pulse, reads the
// base and index registers, and presents the effective address one cycle
// later, or after one memory read in the pointer-to-pointer mode.
// Assumes the register read ports return data combinationally.
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IMMW = 16,
    parameter int NREG = 16,
    localparam int RSW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      mode,
    input  logic [IMMW-1:0] imm,
    input  logic [RSW-1:0]  base_sel,
    input  logic [RSW-1:0]  index_sel,
    input  logic [1:0]      size,
    output logic [RSW-1:0]  rd_a_addr,
    input  logic [AW-1:0]   rd_a_data,
    output logic [RSW-1:0]  rd_b_addr,
    input  logic [AW-1:0]   rd_b_data,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [AW-1:0]   mem_rdata,
    output logic            wb_en,
    output logic [RSW-1:0]  wb_sel,
    output logic [AW-1:0]   wb_data,
    output logic            addr_valid,
    output logic [AW-1:0]   addr_out,
    output logic            illegal,
    output logic            busy
);
    amode_t        mode_e;
    logic [AW-1:0] ea;
    logic [AW-1:0] wb_val;
    logic          is_auto;
    logic          is_bad;
    logic          accept;
    logic          launch;
    logic          hit;
    logic          f_busy;

    // Route selectors to the register read ports and qualify the start.
    always_comb begin
        mode_e    = amode_t'(mode);
        rd_a_addr = base_sel;
        rd_b_addr = index_sel;
        accept    = start && !f_busy;
        launch    = accept && (mode_e == AM_MIND);
        busy      = f_busy;
    end

    opaddr_calc #(.AW(AW), .IMMW(IMMW)) i_calc (
        .mode    (mode_e),
        .imm     (imm),
        .base    (rd_a_data),
        .index   (rd_b_data),
        .size    (size),
        .ea      (ea),
        .wb_val  (wb_val),
        .is_auto (is_auto),
        .is_bad  (is_bad)
    );

    opaddr_fetch #(.AW(AW)) i_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .ptr      (rd_a_data),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .hit      (hit),
        .busy     (f_busy)
    );

    // Register the result strobes, address and base writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
            illegal    <= 1'b0;
            wb_en      <= 1'b0;
            wb_sel     <= '0;
            wb_data    <= '0;
        end else begin
            addr_valid <= 1'b0;
            illegal    <= 1'b0;
            wb_en      <= 1'b0;
            if (hit) begin
                addr_valid <= 1'b1;
                addr_out   <= mem_rdata;
            end else if (accept && !launch) begin
                if (is_bad) begin
                    illegal <= 1'b1;
                end else begin
                    addr_valid <= 1'b1;
                    addr_out   <= ea;
                    wb_en      <= is_auto;
                    wb_sel     <= base_sel;
                    wb_data    <= wb_val;
                end
            end
        end
    end

    // R10
    // flag_excl_chk: an address and an illegal flag never appear together
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && illegal));

    // R12
    // wb_with_valid_chk: writeback only accompanies a valid address
    wb_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> addr_valid);

    // R2
    // direct_latency_chk: a direct-mode start answers on the next cycle
    direct_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != 3'd4) |=> (addr_valid || illegal));

    // R11
    // busy_quiet_chk: nothing is reported in the cycle after a blocked start
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !mem_ack) |=> !illegal && !wb_en);

    // R12
    // valid_pulse_chk: a direct result strobe lasts one cycle
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !mem_req && !start) |=> !addr_valid);

endmodule

// File: tb/test_opaddr_gen.sv
module test_opaddr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] imm = '0;
    logic [3:0]  base_sel = '0;
    logic [3:0]  index_sel = '0;
    logic [1:0]  size = '0;
    logic [3:0]  rd_a_addr, rd_b_addr;
    logic [31:0] rd_a_data, rd_b_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wb_en;
    logic [3:0]  wb_sel;
    logic [31:0] wb_data;
    logic        addr_valid;
    logic [31:0] addr_out;
    logic        illegal;
    logic        busy;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rf [16];

    always #2.5 clk = ~clk;

    assign rd_a_data = rf[rd_a_addr];
    assign rd_b_data = rf[rd_b_addr];

    always @(posedge clk) if (wb_en) rf[wb_sel] <= wb_data;

    opaddr_gen i_opaddr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .imm(imm),
        .base_sel(base_sel), .index_sel(index_sel), .size(size),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_data(wb_data), .addr_valid(addr_valid), .addr_out(addr_out),
        .illegal(illegal), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Pulse start for one cycle; returns at the negedge after the result edge.
    task automatic issue(input logic [2:0] m, input logic [15:0] im,
                         input logic [3:0] b, input logic [3:0] x, input logic [1:0] sz);
        @(negedge clk);
        start = 1'b1; mode = m; imm = im; base_sel = b; index_sel = x; size = sz;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 valid", {31'b0, addr_valid}, 32'd0);
        check("R1 illegal", {31'b0, illegal}, 32'd0);
        check("R1 wb_en", {31'b0, wb_en}, 32'd0);
        check("R1 mem_req", {31'b0, mem_req}, 32'd0);
        check("R1 busy", {31'b0, busy}, 32'd0);
    endtask

    task automatic t_abs();
        issue(3'd0, 16'hF234, 4'd1, 4'd2, 2'd0);
        check("R2 valid", {31'b0, addr_valid}, 32'd1);
        check("R2 addr", addr_out, 32'h0000_F234);
        check("R12 no wb", {31'b0, wb_en}, 32'd0);
        @(negedge clk);
        check("R12 pulse", {31'b0, addr_valid}, 32'd0);
    endtask

    task automatic t_rind();
        issue(3'd1, 16'h0, 4'd1, 4'd0, 2'd0);
        check("R3 valid", {31'b0, addr_valid}, 32'd1);
        check("R3 addr", addr_out, 32'h1000_0040);
    endtask

    task automatic t_disp();
        issue(3'd2, 16'h0010, 4'd1, 4'd0, 2'd0);
        check("R4 pos", addr_out, 32'h1000_0050);
        issue(3'd2, 16'hFFF0, 4'd1, 4'd0, 2'd0);
        check("R4 neg", addr_out, 32'h1000_0030);
    endtask

    task automatic t_idx();
        issue(3'd3, 16'h0, 4'd1, 4'd2, 2'd0);
        check("R5 sum", addr_out, 32'h1000_0048);
        issue(3'd3, 16'h0, 4'd4, 4'd5, 2'd0);
        check("R5 wrap", addr_out, 32'h0000_0002);
    endtask

    task automatic t_auto();
        rf[6] = 32'h0000_2000;
        issue(3'd5, 16'h0, 4'd6, 4'd0, 2'd2);
        check("R7 addr", addr_out, 32'h0000_2000);
        check("R7 wb_en", {31'b0, wb_en}, 32'd1);
        check("R7 wb_sel", {28'b0, wb_sel}, 32'd6);
        check("R9 step4", wb_data, 32'h0000_2004);
        issue(3'd5, 16'h0, 4'd6, 4'd0, 2'd0);
        check("R9 step1", wb_data, 32'h0000_2005);
        issue(3'd6, 16'h0, 4'd6, 4'd0, 2'd1);
        check("R8 addr", addr_out, 32'h0000_2005);
        check("R9 step2 dec", wb_data, 32'h0000_2003);
        issue(3'd6, 16'h0, 4'd6, 4'd0, 2'd3);
        check("R9 code3 dec", wb_data, 32'h0000_1FFF);
        issue(3'd1, 16'h0, 4'd6, 4'd0, 2'd0);
        check("R8 readback", addr_out, 32'h0000_1FFF);
        check("R12 no wb ptr", {31'b0, wb_en}, 32'd0);
    endtask

    task automatic t_bad();
        issue(3'd7, 16'h1234, 4'd6, 4'd0, 2'd2);
        check("R10 flag", {31'b0, illegal}, 32'd1);
        check("R10 no valid", {31'b0, addr_valid}, 32'd0);
        check("R10 no wb", {31'b0, wb_en}, 32'd0);
        @(negedge clk);
        check("R10 pulse", {31'b0, illegal}, 32'd0);
    endtask

    task automatic t_mind();
        rf[3] = 32'h0000_0100;
        issue(3'd4, 16'h0, 4'd3, 4'd0, 2'd0);
        check("R6 req", {31'b0, mem_req}, 32'd1);
        check("R6 maddr", mem_addr, 32'h0000_0100);
        check("R11 busy", {31'b0, busy}, 32'd1);
        check("R6 no early valid", {31'b0, addr_valid}, 32'd0);
        issue(3'd0, 16'h0055, 4'd0, 4'd0, 2'd0);
        check("R11 ignored", {31'b0, addr_valid}, 32'd0);
        issue(3'd5, 16'h0, 4'd3, 4'd0, 2'd0);
        check("R11 no wb", {31'b0, wb_en}, 32'd0);
        @(negedge clk);
        check("R6 held", {31'b0, mem_req}, 32'd1);
        check("R6 addr held", mem_addr, 32'h0000_0100);
        mem_ack = 1'b1; mem_rdata = 32'hDEAD_BEE0;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
        check("R6 valid", {31'b0, addr_valid}, 32'd1);
        check("R6 addr", addr_out, 32'hDEAD_BEE0);
        check("R6 req drop", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        check("R12 single", {31'b0, addr_valid}, 32'd0);
        check("R11 idle", {31'b0, busy}, 32'd0);
        issue(3'd1, 16'h0, 4'd3, 4'd0, 2'd0);
        check("R11 base kept", addr_out, 32'h0000_0100);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        rf[1] = 32'h1000_0040;
        rf[2] = 32'h0000_0008;
        rf[4] = 32'hFFFF_FFFF;
        rf[5] = 32'h0000_0003;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_abs();
        t_rind();
        t_disp();
        t_idx();
        t_auto();
        t_bad();
        t_mind();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule